// File: doc/BRIEF.md
# Partition Power-Up Sequencer

This block wakes one power partition out of a set of `NPART` partitions and walks it through a fixed, safe bring-up order. A one-cycle start pulse names the partition. The sequencer then does seven things in order. It puts the partition into reset and stops its clock. It asks for power unless power is already good. It turns the clock back on and waits a settle time. It commands the isolation clamps off and finally lets the partition out of reset. Power-good and clamp state are polled against a timeout counted in microsecond ticks. The ticks come from a prescaler on the system clock.

Four per-step failure inputs report that a step the sequencer commanded did not take effect. A polling timeout is also a failure. Any failure starts a rollback that leaves the partition held in reset and powered down. The rollback path depends on where the failure struck. If the clock had already been turned on and the failure came late, the clock is gated off first. At the end, a done flag or an error flag with a code is raised. The flag stays up until the next start.

States: `S_IDLE` waits for start. `S_RST_ON`, `S_CLK_OFF`, `S_PWR_CHK`, `S_PWR_WAIT`, `S_CLK_ON`, `S_SETTLE`, `S_CLAMP_CMD`, `S_CLAMP_WAIT` and `S_RST_REL` form the forward path. `S_RB_CLK`, `S_RB_RST` and `S_RB_PWR` form the rollback path.

Transitions:
- `S_IDLE`→`S_RST_ON` on start.
- Each forward step advances to the next one.
- `S_PWR_CHK`→`S_CLK_ON` when power is already good (skip).
- `S_PWR_WAIT`→`S_CLK_ON` on power-good.
- `S_CLAMP_WAIT`→`S_RST_REL` on unclamp.
- `S_RST_REL`→`S_IDLE` on success.
- Failures in `S_RST_ON`, `S_CLK_OFF`, `S_PWR_WAIT` and `S_CLK_ON` go to `S_RB_RST`.
- Failures in `S_CLAMP_WAIT` and `S_RST_REL` go to `S_RB_CLK`.
- The rollback runs `S_RB_CLK`→`S_RB_RST`→`S_RB_PWR`→`S_IDLE`.

Top module: `part_wake_seq`

## Requirements
- R1: After reset every partition is held in reset (`part_rst_o` all ones) with its clock gated (`part_clk_en_o` all zeros). No toggle or clamp pulse is issued, and `done_o`, `err_o` and `err_code_o` are zero.
- R2: A successful run drives the selected partition in this order: reset asserted, clock stopped, power toggle pulse, clock enabled, clamp-release pulse, reset released. It then sets `done_o`. Toggle and clamp pulses are one cycle long and one-hot, and reset is released only after the partition reports unclamped.
- R3: If the selected partition's power-good is already high when power would be requested, no toggle pulse is issued and the sequence goes straight on to clock enable.
- R4: If power-good stays low for `POLL_TICKS` ticks after the toggle, the run fails with code 3. The rollback asserts reset and issues no further toggle, because the partition is unpowered.
- R5: The clamp-release pulse comes exactly `SETTLE_TICKS*TICK_DIV+2` cycles after the clock enable rises, and only while that partition's clock is enabled.
- R6: If the partition is still clamped `POLL_TICKS` ticks after the clamp command, the run fails with code 5. The rollback gates the clock off, asserts reset and toggles the power off.
- R7: `step_fail_i` bit 0 (reset assert), bit 1 (clock stop) and bit 2 (clock enable) are sampled only in their own step. They fail the run with codes 1, 2 and 4. The rollback asserts reset without touching the clock.
- R8: `step_fail_i` bit 3 (reset release) fails the run with code 6. The rollback gates the clock off, keeps reset asserted and toggles the power off.
- R9: A start pulse that arrives while a run is in progress is ignored. The selection does not change and no other partition's outputs move.
- R10: `done_o` and `err_o` are never both high, and `err_code_o` is 0 while `done_o` is high. The flags hold until the next start and are cleared on the edge that accepts it.
- R11: The rollback issues a power-off toggle only when the selected partition's power-good is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to wake a partition |
| part_id_i | input | IW | Partition index, sampled with start |
| step_fail_i | input | 4 | Per-step failure: 0 reset assert, 1 clock stop, 2 clock enable, 3 reset release |
| pwr_good_i | input | NPART | Power-good per partition |
| clamped_i | input | NPART | Clamps still engaged, per partition |
| part_rst_o | output | NPART | Partition reset, 1 = held in reset |
| part_clk_en_o | output | NPART | Partition clock enable |
| pwr_toggle_o | output | NPART | One-cycle power-switch toggle pulse |
| clamp_rel_o | output | NPART | One-cycle clamp-release command pulse |
| done_o | output | 1 | Last run completed successfully |
| err_o | output | 1 | Last run failed and was rolled back |
| err_code_o | output | 3 | Failure code (0 none, 1..6 as in R4, R6, R7, R8) |

## Verification
The sequence is first run on every partition from the powered-down state. This exposes the full event order, the toggle and the settle interval. It is then run on every partition while it is already up, which separates the power-good skip from the ordinary path. Each failure bit and each of the two timeouts is injected in turn. Together these distinguish the early rollback from the late one and show whether the power-off toggle depends on power-good. A second start during a run, and the idle gaps after done and after an error, show that busy starts are ignored and that the flags hold.

// File: rtl/pws_pkg.sv
package pws_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RST_ON,
        S_CLK_OFF,
        S_PWR_CHK,
        S_PWR_WAIT,
        S_CLK_ON,
        S_SETTLE,
        S_CLAMP_CMD,
        S_CLAMP_WAIT,
        S_RST_REL,
        S_RB_CLK,
        S_RB_RST,
        S_RB_PWR
    } seq_state_t;

    typedef enum logic [2:0] {
        E_NONE      = 3'd0,
        E_RST_SET   = 3'd1,
        E_CLK_STOP  = 3'd2,
        E_PWR_TMO   = 3'd3,
        E_CLK_EN    = 3'd4,
        E_CLAMP_TMO = 3'd5,
        E_RST_CLR   = 3'd6
    } seq_err_t;

    // bit positions of the per-step failure input
    localparam int FB_RST_SET  = 0;
    localparam int FB_CLK_STOP = 1;
    localparam int FB_CLK_EN   = 2;
    localparam int FB_RST_CLR  = 3;
    localparam int FB_W        = 4;

    typedef struct packed {
        logic rst_set;
        logic rst_clr;
        logic clk_set;
        logic clk_clr;
        logic toggle;
        logic clamp;
    } seq_cmd_t;

endpackage

// File: rtl/pws_tick_gen.sv
module pws_tick_gen #(
    parameter int DIV = 125,
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);

    logic [PW-1:0] pre_q;

    assign tick_o = (pre_q == PW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            pre_q <= '0;
        end else if (tick_o) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/pws_step_timer.sv
module pws_step_timer #(
    parameter int TW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] limit_i,
    input  logic          tick_i,
    output logic          expired_o
);

    logic [TW-1:0] cnt_q;

    assign expired_o = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= limit_i;
        end else if (tick_i && !expired_o) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/pws_part_bank.sv
module pws_part_bank
    import pws_pkg::*;
#(
    parameter int NPART = 4,
    parameter int IW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IW-1:0]    sel_i,
    input  seq_cmd_t         cmd_i,
    output logic [NPART-1:0] rst_o,
    output logic [NPART-1:0] clk_en_o,
    output logic [NPART-1:0] toggle_o,
    output logic [NPART-1:0] clamp_o
);

    for (genvar g = 0; g < NPART; g++) begin : g_part
        logic hit;
        assign hit = (sel_i == IW'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rst_o[g]    <= 1'b1;
                clk_en_o[g] <= 1'b0;
                toggle_o[g] <= 1'b0;
                clamp_o[g]  <= 1'b0;
            end else begin
                toggle_o[g] <= hit && cmd_i.toggle;
                clamp_o[g]  <= hit && cmd_i.clamp;
                if (hit && cmd_i.rst_set) begin
                    rst_o[g] <= 1'b1;
                end else if (hit && cmd_i.rst_clr) begin
                    rst_o[g] <= 1'b0;
                end
                if (hit && cmd_i.clk_clr) begin
                    clk_en_o[g] <= 1'b0;
                end else if (hit && cmd_i.clk_set) begin
                    clk_en_o[g] <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pws_ctrl.sv
module pws_ctrl
    import pws_pkg::*;
#(
    parameter int NPART        = 4,
    parameter int IW           = 2,
    parameter int TW           = 7,
    parameter int POLL_TICKS   = 100,
    parameter int SETTLE_TICKS = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [IW-1:0]    id_i,
    input  logic [FB_W-1:0]  fail_i,
    input  logic [NPART-1:0] pg_i,
    input  logic [NPART-1:0] clamped_i,
    input  logic             tmr_expired_i,
    output logic             tmr_load_o,
    output logic [TW-1:0]    tmr_limit_o,
    output seq_cmd_t         cmd_o,
    output logic [IW-1:0]    sel_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic [2:0]       code_o
);

    seq_state_t state_q, state_n;
    seq_err_t   code_q, fail_code;
    logic       fail_now;
    logic [IW-1:0] sel_q;
    logic       pg_sel, clamped_sel;

    assign pg_sel      = pg_i[sel_q];
    assign clamped_sel = clamped_i[sel_q];
    assign sel_o       = sel_q;
    assign busy_o      = (state_q != S_IDLE);
    assign code_o      = code_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // transitions
    always_comb begin
        state_n   = state_q;
        fail_now  = 1'b0;
        fail_code = E_NONE;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) state_n = S_RST_ON;
            end
            S_RST_ON: begin
                if (fail_i[FB_RST_SET]) begin
                    state_n   = S_RB_RST;
                    fail_now  = 1'b1;
                    fail_code = E_RST_SET;
                end else begin
                    state_n = S_CLK_OFF;
                end
            end
            S_CLK_OFF: begin
                if (fail_i[FB_CLK_STOP]) begin
                    state_n   = S_RB_RST;
                    fail_now  = 1'b1;
                    fail_code = E_CLK_STOP;
                end else begin
                    state_n = S_PWR_CHK;
                end
            end
            S_PWR_CHK: begin
                state_n = pg_sel ? S_CLK_ON : S_PWR_WAIT;
            end
            S_PWR_WAIT: begin
                if (pg_sel) begin
                    state_n = S_CLK_ON;
                end else if (tmr_expired_i) begin
                    state_n   = S_RB_RST;
                    fail_now  = 1'b1;
                    fail_code = E_PWR_TMO;
                end
            end
            S_CLK_ON: begin
                if (fail_i[FB_CLK_EN]) begin
                    state_n   = S_RB_RST;
                    fail_now  = 1'b1;
                    fail_code = E_CLK_EN;
                end else begin
                    state_n = S_SETTLE;
                end
            end
            S_SETTLE: begin
                if (tmr_expired_i) state_n = S_CLAMP_CMD;
            end
            S_CLAMP_CMD: begin
                state_n = S_CLAMP_WAIT;
            end
            S_CLAMP_WAIT: begin
                if (!clamped_sel) begin
                    state_n = S_RST_REL;
                end else if (tmr_expired_i) begin
                    state_n   = S_RB_CLK;
                    fail_now  = 1'b1;
                    fail_code = E_CLAMP_TMO;
                end
            end
            S_RST_REL: begin
                if (fail_i[FB_RST_CLR]) begin
                    state_n   = S_RB_CLK;
                    fail_now  = 1'b1;
                    fail_code = E_RST_CLR;
                end else begin
                    state_n = S_IDLE;
                end
            end
            S_RB_CLK: state_n = S_RB_RST;
            S_RB_RST: state_n = S_RB_PWR;
            S_RB_PWR: state_n = S_IDLE;
            default:  state_n = S_IDLE;
        endcase
    end

    // outputs: partition commands and timer control
    always_comb begin
        cmd_o       = '0;
        tmr_load_o  = 1'b0;
        tmr_limit_o = '0;
        unique case (state_q)
            S_RST_ON:  cmd_o.rst_set = !fail_i[FB_RST_SET];
            S_CLK_OFF: cmd_o.clk_clr = !fail_i[FB_CLK_STOP];
            S_PWR_CHK: begin
                cmd_o.toggle = !pg_sel;
                tmr_load_o   = !pg_sel;
                tmr_limit_o  = TW'(POLL_TICKS);
            end
            S_CLK_ON: begin
                cmd_o.clk_set = !fail_i[FB_CLK_EN];
                tmr_load_o    = !fail_i[FB_CLK_EN];
                tmr_limit_o   = TW'(SETTLE_TICKS);
            end
            S_CLAMP_CMD: begin
                cmd_o.clamp = 1'b1;
                tmr_load_o  = 1'b1;
                tmr_limit_o = TW'(POLL_TICKS);
            end
            S_RST_REL: cmd_o.rst_clr = !fail_i[FB_RST_CLR];
            S_RB_CLK:  cmd_o.clk_clr = 1'b1;
            S_RB_RST:  cmd_o.rst_set = 1'b1;
            S_RB_PWR:  cmd_o.toggle  = pg_sel;
            default: begin
                cmd_o = '0;
            end
        endcase
    end

    // selection and result flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            done_o <= 1'b0;
            err_o  <= 1'b0;
            code_q <= E_NONE;
        end else begin
            if (state_q == S_IDLE && start_i) begin
                sel_q  <= id_i;
                done_o <= 1'b0;
                err_o  <= 1'b0;
                code_q <= E_NONE;
            end
            if (fail_now) begin
                code_q <= fail_code;
            end
            if (state_q == S_RST_REL && state_n == S_IDLE) begin
                done_o <= 1'b1;
            end
            if (state_q == S_RB_PWR) begin
                err_o <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/part_wake_seq.sv
module part_wake_seq
    import pws_pkg::*;
#(
    parameter  int NPART        = 4,
    parameter  int TICK_DIV     = 125,
    parameter  int POLL_TICKS   = 100,
    parameter  int SETTLE_TICKS = 20,
    localparam int IW   = (NPART > 1) ? $clog2(NPART) : 1,
    localparam int TMAX = (POLL_TICKS > SETTLE_TICKS) ? POLL_TICKS : SETTLE_TICKS,
    localparam int TW   = $clog2(TMAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [IW-1:0]    part_id_i,
    input  logic [3:0]       step_fail_i,
    input  logic [NPART-1:0] pwr_good_i,
    input  logic [NPART-1:0] clamped_i,
    output logic [NPART-1:0] part_rst_o,
    output logic [NPART-1:0] part_clk_en_o,
    output logic [NPART-1:0] pwr_toggle_o,
    output logic [NPART-1:0] clamp_rel_o,
    output logic             done_o,
    output logic             err_o,
    output logic [2:0]       err_code_o
);

    logic          tick;
    logic          tmr_load;
    logic [TW-1:0] tmr_limit;
    logic          tmr_expired;
    seq_cmd_t      cmd;
    logic [IW-1:0] sel;
    logic          busy;

    pws_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (tmr_load),
        .tick_o (tick)
    );

    pws_step_timer #(.TW(TW)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .limit_i   (tmr_limit),
        .tick_i    (tick),
        .expired_o (tmr_expired)
    );

    pws_ctrl #(
        .NPART        (NPART),
        .IW           (IW),
        .TW           (TW),
        .POLL_TICKS   (POLL_TICKS),
        .SETTLE_TICKS (SETTLE_TICKS)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .id_i          (part_id_i),
        .fail_i        (step_fail_i),
        .pg_i          (pwr_good_i),
        .clamped_i     (clamped_i),
        .tmr_expired_i (tmr_expired),
        .tmr_load_o    (tmr_load),
        .tmr_limit_o   (tmr_limit),
        .cmd_o         (cmd),
        .sel_o         (sel),
        .busy_o        (busy),
        .done_o        (done_o),
        .err_o         (err_o),
        .code_o        (err_code_o)
    );

    pws_part_bank #(.NPART(NPART), .IW(IW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (sel),
        .cmd_i    (cmd),
        .rst_o    (part_rst_o),
        .clk_en_o (part_clk_en_o),
        .toggle_o (pwr_toggle_o),
        .clamp_o  (clamp_rel_o)
    );

endmodule

// File: rtl/pws_checker.sv
module pws_checker #(
    parameter int NPART = 4,
    parameter int IW    = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy,
    input logic [IW-1:0]    sel,
    input logic [NPART-1:0] clamped_i,
    input logic [NPART-1:0] part_rst_o,
    input logic [NPART-1:0] part_clk_en_o,
    input logic [NPART-1:0] pwr_toggle_o,
    input logic [NPART-1:0] clamp_rel_o,
    input logic             done_o,
    input logic             err_o,
    input logic [2:0]       err_code_o
);

    p_done_err_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    p_done_clean_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (err_code_o == 3'd0));

    p_err_has_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (err_code_o != 3'd0));

    p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_i) |=> $stable(sel));

    p_pulse_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pwr_toggle_o) && $onehot0(clamp_rel_o));

    p_clamp_clock_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|clamp_rel_o) |-> ((clamp_rel_o & part_clk_en_o) == clamp_rel_o));

    p_release_unclamped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~part_rst_o & $past(part_rst_o)))
            |-> ((~part_rst_o & $past(part_rst_o) & $past(clamped_i)) == '0));

    p_err_reset_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> part_rst_o[sel]);

    p_late_clock_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(err_o) && (err_code_o == 3'd5 || err_code_o == 3'd6))
            |-> !part_clk_en_o[sel]);

endmodule

bind part_wake_seq pws_checker #(.NPART(NPART), .IW(IW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .busy          (busy),
    .sel           (sel),
    .clamped_i     (clamped_i),
    .part_rst_o    (part_rst_o),
    .part_clk_en_o (part_clk_en_o),
    .pwr_toggle_o  (pwr_toggle_o),
    .clamp_rel_o   (clamp_rel_o),
    .done_o        (done_o),
    .err_o         (err_o),
    .err_code_o    (err_code_o)
);

// File: tb/part_wake_seq_tb.sv
module part_wake_seq_tb;

    localparam int NP     = 4;
    localparam int DIV    = 4;
    localparam int POLL   = 6;
    localparam int SETL   = 5;
    localparam int PG_DLY = 7;
    localparam int CL_DLY = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    pid = '0;
    logic [3:0]    fail = '0;
    logic [NP-1:0] pg = '0;
    logic [NP-1:0] clamped = '1;
    logic [NP-1:0] rst_o, clk_o, tog_o, clr_o;
    logic          done_o, err_o;
    logic [2:0]    code_o;

    always #4 clk = ~clk;

    part_wake_seq #(
        .NPART(NP), .TICK_DIV(DIV), .POLL_TICKS(POLL), .SETTLE_TICKS(SETL)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .part_id_i(pid),
        .step_fail_i(fail), .pwr_good_i(pg), .clamped_i(clamped),
        .part_rst_o(rst_o), .part_clk_en_o(clk_o), .pwr_toggle_o(tog_o),
        .clamp_rel_o(clr_o), .done_o(done_o), .err_o(err_o), .err_code_o(code_o)
    );

    int n_chk = 0;
    int n_fail = 0;

    // partition model and event monitor state
    logic [NP-1:0] pw = '0, brk_pwr = '0, brk_cl = '0;
    int            pcnt [NP];
    int            ccnt [NP];
    int            cyc = 0;
    int            mon_id = 0;
    logic [31:0]   ev_log = '0;
    int            tog_cnt = 0;
    int            clk_cyc = -1, clamp_cyc = -1;
    logic          other_evt = 1'b0;
    logic [NP-1:0] prv_rst, prv_clk;
    logic          flag_after_start = 1'b0;

    initial begin
        for (int i = 0; i < NP; i++) begin
            pcnt[i] = 0;
            ccnt[i] = 0;
        end
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n) begin
                for (int i = 0; i < NP; i++) begin
                    if (i == mon_id) begin
                        if (rst_o[i] && !prv_rst[i]) ev_log = {ev_log[27:0], 4'd1};
                        if (!clk_o[i] && prv_clk[i]) ev_log = {ev_log[27:0], 4'd2};
                        if (tog_o[i]) begin
                            ev_log = {ev_log[27:0], 4'd3};
                            tog_cnt++;
                        end
                        if (clk_o[i] && !prv_clk[i]) begin
                            ev_log = {ev_log[27:0], 4'd4};
                            clk_cyc = cyc;
                        end
                        if (clr_o[i]) begin
                            ev_log = {ev_log[27:0], 4'd5};
                            clamp_cyc = cyc;
                        end
                        if (!rst_o[i] && prv_rst[i]) ev_log = {ev_log[27:0], 4'd6};
                    end else if (tog_o[i] || clr_o[i] || (rst_o[i] != prv_rst[i])
                                 || (clk_o[i] != prv_clk[i])) begin
                        other_evt = 1'b1;
                    end
                    if (tog_o[i] && !(brk_pwr[i] && !pw[i])) pcnt[i] = PG_DLY;
                    if (pcnt[i] > 0) begin
                        pcnt[i]--;
                        if (pcnt[i] == 0) begin
                            pw[i] = !pw[i];
                            if (!pw[i]) begin
                                clamped[i] = 1'b1;
                                ccnt[i] = 0;
                            end
                        end
                    end
                    if (clr_o[i] && !brk_cl[i] && pw[i]) ccnt[i] = CL_DLY;
                    if (ccnt[i] > 0) begin
                        ccnt[i]--;
                        if (ccnt[i] == 0 && pw[i]) clamped[i] = 1'b0;
                    end
                end
                pg = pw;
            end
            prv_rst = rst_o;
            prv_clk = clk_o;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run_op(input int id, input logic [3:0] f, input bit glitch);
        int w;
        mon_id = id;
        ev_log = '0;
        tog_cnt = 0;
        other_evt = 1'b0;
        clk_cyc = -1;
        clamp_cyc = -1;
        @(negedge clk);
        pid = 2'(id);
        fail = f;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        flag_after_start = done_o || err_o;
        w = 0;
        while (!(done_o || err_o) && w < 600) begin
            if (glitch && w == 8) begin
                pid = 2'((id + 1) % NP);
                start = 1'b1;
            end else begin
                start = 1'b0;
                pid = 2'(id);
            end
            @(negedge clk);
            w++;
        end
        start = 1'b0;
        if (w >= 600) chk(1'b0, "operation hung", w, 600);
        repeat (20) @(negedge clk);
        fail = '0;
    endtask

    task automatic expect_op(input string tag, input int id, input bit ex_done,
                             input int ex_code, input logic [31:0] ex_log,
                             input int ex_tog, input bit ex_rst, input bit ex_clk,
                             input bit ex_pw);
        chk(done_o == ex_done && err_o == !ex_done, {tag, " done/err"},
            int'({done_o, err_o}), int'({ex_done, !ex_done}));
        chk(int'(code_o) == ex_code, {tag, " code"}, int'(code_o), ex_code);
        chk(ev_log == ex_log, {tag, " event order"}, int'(ev_log), int'(ex_log));
        chk(tog_cnt == ex_tog, {tag, " toggles"}, tog_cnt, ex_tog);
        chk(rst_o[id] == ex_rst && clk_o[id] == ex_clk, {tag, " final rst/clk"},
            int'({rst_o[id], clk_o[id]}), int'({ex_rst, ex_clk}));
        chk(pw[id] == ex_pw, {tag, " final power"}, int'(pw[id]), int'(ex_pw));
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rst_o == '1, "R1 reset held", int'(rst_o), 15);
        chk(clk_o == '0 && tog_o == '0 && clr_o == '0, "R1 clocks/pulses",
            int'({clk_o, tog_o, clr_o}), 0);
        chk(!done_o && !err_o && code_o == 3'd0, "R1 flags",
            int'({done_o, err_o, code_o}), 0);

        // R2/R5: fresh bring-up of every partition
        for (int id = 0; id < NP; id++) begin
            run_op(id, 4'b0000, 1'b0);
            expect_op("R2 fresh", id, 1'b1, 0, 32'h3456, 1, 1'b0, 1'b1, 1'b1);
            chk(clamp_cyc - clk_cyc == SETL * DIV + 2, "R5 settle interval",
                clamp_cyc - clk_cyc, SETL * DIV + 2);
        end

        // R3: already powered, toggle skipped
        for (int id = 0; id < NP; id++) begin
            run_op(id, 4'b0000, 1'b0);
            expect_op("R3 skip", id, 1'b1, 0, 32'h12456, 0, 1'b0, 1'b1, 1'b1);
        end

        // R8: reset release failure, late rollback from powered state
        for (int id = 0; id < NP; id++) begin
            run_op(id, 4'b1000, 1'b0);
            expect_op("R8 rst release fail", id, 1'b0, 6, 32'h124523, 1, 1'b1, 1'b0, 1'b0);
        end

        // R7/R11: early failures
        run_op(0, 4'b0001, 1'b0);
        expect_op("R7 R11 rst assert fail", 0, 1'b0, 1, 32'h0, 0, 1'b1, 1'b0, 1'b0);
        run_op(1, 4'b0010, 1'b0);
        expect_op("R7 clk stop fail", 1, 1'b0, 2, 32'h0, 0, 1'b1, 1'b0, 1'b0);
        run_op(2, 4'b0100, 1'b0);
        expect_op("R7 R11 clk enable fail", 2, 1'b0, 4, 32'h33, 2, 1'b1, 1'b0, 1'b0);

        // R4: power-good never arrives
        brk_pwr[3] = 1'b1;
        run_op(3, 4'b0000, 1'b0);
        expect_op("R4 power timeout", 3, 1'b0, 3, 32'h3, 1, 1'b1, 1'b0, 1'b0);
        brk_pwr[3] = 1'b0;

        // R6: clamps never release
        brk_cl[0] = 1'b1;
        run_op(0, 4'b0000, 1'b0);
        expect_op("R6 clamp timeout", 0, 1'b0, 5, 32'h34523, 2, 1'b1, 1'b0, 1'b0);
        brk_cl[0] = 1'b0;

        // R10: error held, cleared on next start
        repeat (30) @(negedge clk);
        chk(err_o && !done_o, "R10 error held", int'({done_o, err_o}), 1);
        run_op(0, 4'b0000, 1'b0);
        chk(!flag_after_start, "R10 flags cleared at start", int'(flag_after_start), 0);
        expect_op("R10 recovery run", 0, 1'b1, 0, 32'h3456, 1, 1'b0, 1'b1, 1'b1);

        // R9: start while busy is ignored
        run_op(1, 4'b0000, 1'b1);
        expect_op("R9 busy start", 1, 1'b1, 0, 32'h3456, 1, 1'b0, 1'b1, 1'b1);
        chk(!other_evt, "R9 other partition untouched", int'(other_evt), 0);
        ev_log = '0;
        repeat (40) @(negedge clk);
        chk(ev_log == '0 && done_o && !err_o, "R9 R10 no restart, done held",
            int'({ev_log[3:0], done_o, err_o}), 2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule